// File: doc/BRIEF.md
# Bit-Serial Port I/O Controller

This block sits on the processor side of an I/O space in which every address holds exactly one bit. The I/O space has its own meaning but is driven on the same 12 address lines as memory, so 4096 single-bit locations can be reached. Peripherals watch the address lines and decode their own bits. The block drives one serial data-out line and a strobe that tells peripherals to latch that bit, and it reads back one serial data-in line.

A command has an operation code, a base address, a bit count and a write word. Three single-bit commands are supported: force a bit to one, force a bit to zero, and sample a bit into a flag. Two field commands are also supported. A store shifts out 1 to 16 bits and a load shifts in 1 to 16 bits. In both, bit i of the word maps to I/O address base+i. Because each address is one bit, a peripheral can own a port of any width, such as 3, 5 or 7 bits, with no padding.

The controller works through the field one bit at a time. It holds `busy` high until the last bit is complete, then pulses `done` for one cycle.

Top module: `bitPortCtl`

## Requirements
- R1: Operation code 0 (set one) drives a 1 on `ioDout` at address `cmdBase` with exactly one `ioClk` pulse, and `busy` is high for 3 cycles.
- R2: Operation code 1 (set zero) drives a 0 on `ioDout` at address `cmdBase` with exactly one `ioClk` pulse, and `busy` is high for 3 cycles.
- R3: Operation code 2 (test) presents `cmdBase`, samples `ioDin` in the second cycle, and places the sampled value on `testFlag`; `busy` is high for 2 cycles and no strobe is issued.
- R4: Operation code 3 (store) sends `cmdData` bit i to address `cmdBase+i`, least significant bit first. Count 0 means 16 bits, counts 1 to 8 touch only the low byte, and `busy` is high for 3 cycles per bit.
- R5: Operation code 4 (load) places the bit read from address `cmdBase+i` in `rdData[i]` and clears every bit above the count; `busy` is high for 2 cycles per bit.
- R6: Each `ioClk` pulse lasts one cycle. `ioAddr` and `ioDout` hold the same value in the cycle before the pulse, during the pulse, and in the cycle after it.
- R7: During a field transfer the address steps up by one for each bit and wraps from 4095 to 0.
- R8: A command presented while `busy` is high is ignored, and so are operation codes 5 to 7.
- R9: `done` is high for exactly one cycle, in the first cycle in which `busy` is low after a command.
- R10: After reset `busy`, `done` and `ioClk` are low and `ioAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request, accepted when idle |
| cmdOp | input | 3 | Operation code (0 one, 1 zero, 2 test, 3 store, 4 load) |
| cmdBase | input | 12 | First I/O bit address |
| cmdCount | input | 4 | Field length, 0 meaning 16 |
| cmdData | input | 16 | Word to shift out on a store |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Word gathered by a load |
| testFlag | output | 1 | Bit sampled by a test |
| ioAddr | output | 12 | I/O bit address on the shared address lines |
| ioDout | output | 1 | Serial data out |
| ioClk | output | 1 | Data-out strobe |
| ioDin | input | 1 | Serial data in |

## Verification
The hardest case to reach is a field that crosses address 4095. At that point the address counter wraps in the middle of a command, and a store and a load must still agree bit for bit. Directed commands based at 4090 cover this case, using counts 0 and 9 so that both the 16-bit encoding and a count above one byte are exercised. A second hard case is a request that arrives mid-transfer. The bench raises a conflicting set-one request during a running store, then checks the peripheral model to show that the target bit never changed.

// File: rtl/bitPortPkg.sv
package bitPortPkg;
  typedef enum logic [2:0] {
    OP_ONE   = 3'd0,
    OP_ZERO  = 3'd1,
    OP_TEST  = 3'd2,
    OP_STORE = 3'd3,
    OP_LOAD  = 3'd4
  } portOpT;

  typedef struct packed {
    logic accept;   // latch command fields
    logic advance;  // move to next bit
    logic capture;  // sample ioDin
  } portCtrlT;
endpackage

// File: rtl/bitPortCtrl.sv
module bitPortCtrl
  import bitPortPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [CNT_W-1:0] cmdCount,
  output portCtrlT   ctrl,
  output logic       busy,
  output logic       done,
  output logic       ioClk
);
  localparam int LEFT_W = CNT_W + 1;
  localparam logic [LEFT_W-1:0] FULL = LEFT_W'(1 << CNT_W);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_PULSE, S_HOLD, S_ADDR, S_SAMP
  } stateT;

  stateT             stateQ;
  logic [LEFT_W-1:0] bitsLeftQ;
  logic              doneQ;
  logic              opValid, isField, isRead, lastBit;

  always_comb begin
    opValid = (cmdOp <= 3'(OP_LOAD));
    isField = (cmdOp == 3'(OP_STORE)) || (cmdOp == 3'(OP_LOAD));
    isRead  = (cmdOp == 3'(OP_TEST))  || (cmdOp == 3'(OP_LOAD));
    lastBit = (bitsLeftQ == LEFT_W'(1));
  end

  always_comb begin
    ctrl         = '0;
    ctrl.accept  = (stateQ == S_IDLE) && cmdValid && opValid;
    ctrl.advance = ((stateQ == S_HOLD) || (stateQ == S_SAMP)) && !lastBit;
    ctrl.capture = (stateQ == S_SAMP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= S_IDLE;
      bitsLeftQ <= '0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (stateQ)
        S_IDLE: if (ctrl.accept) begin
          if (isField)
            bitsLeftQ <= (cmdCount == '0) ? FULL : LEFT_W'(cmdCount);
          else
            bitsLeftQ <= LEFT_W'(1);
          stateQ <= isRead ? S_ADDR : S_SETUP;
        end
        S_SETUP: stateQ <= S_PULSE;
        S_PULSE: stateQ <= S_HOLD;
        S_HOLD, S_SAMP: begin
          if (lastBit) begin
            stateQ <= S_IDLE;
            doneQ  <= 1'b1;
          end else begin
            bitsLeftQ <= bitsLeftQ - LEFT_W'(1);
            stateQ    <= (stateQ == S_HOLD) ? S_SETUP : S_ADDR;
          end
        end
        S_ADDR: stateQ <= S_SAMP;
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  assign busy  = (stateQ != S_IDLE);
  assign done  = doneQ;
  assign ioClk = (stateQ == S_PULSE);
endmodule

// File: rtl/bitPortDatapath.sv
module bitPortDatapath
  import bitPortPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  portCtrlT          ctrl,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              ioDin,
  output logic [ADDR_W-1:0] ioAddr,
  output logic              ioDout,
  output logic [DATA_W-1:0] rdData,
  output logic              testFlag
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] outQ, rdQ;
  logic [IDX_W-1:0]  idxQ;
  logic              isTestQ, flagQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      outQ    <= '0;
      rdQ     <= '0;
      idxQ    <= '0;
      isTestQ <= 1'b0;
      flagQ   <= 1'b0;
    end else if (ctrl.accept) begin
      addrQ   <= cmdBase;
      idxQ    <= '0;
      isTestQ <= (cmdOp == 3'(OP_TEST));
      unique case (cmdOp)
        3'(OP_ONE):  outQ <= DATA_W'(1);
        3'(OP_ZERO): outQ <= '0;
        default:     outQ <= cmdData;
      endcase
      if (cmdOp == 3'(OP_LOAD)) rdQ <= '0;
    end else begin
      if (ctrl.capture) begin
        if (isTestQ) flagQ <= ioDin;
        else         rdQ[idxQ] <= ioDin;
      end
      if (ctrl.advance) begin
        addrQ <= addrQ + ADDR_W'(1);
        outQ  <= outQ >> 1;
        idxQ  <= idxQ + IDX_W'(1);
      end
    end
  end

  assign ioAddr   = addrQ;
  assign ioDout   = outQ[0];
  assign rdData   = rdQ;
  assign testFlag = flagQ;
endmodule

// File: rtl/bitPortCtl.sv
module bitPortCtl
  import bitPortPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 4,
  localparam int DATA_W = 1 << CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [DATA_W-1:0] cmdData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              testFlag,
  output logic [ADDR_W-1:0] ioAddr,
  output logic              ioDout,
  output logic              ioClk,
  input  logic              ioDin
);
  portCtrlT ctrl;

  bitPortCtrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdCount(cmdCount), .ctrl(ctrl), .busy(busy), .done(done), .ioClk(ioClk)
  );

  bitPortDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .cmdOp(cmdOp), .cmdBase(cmdBase),
    .cmdData(cmdData), .ioDin(ioDin), .ioAddr(ioAddr), .ioDout(ioDout),
    .rdData(rdData), .testFlag(testFlag)
  );
endmodule

// File: rtl/bitPortChecker.sv
module bitPortChecker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              ioClk,
  input logic              ioDout,
  input logic [ADDR_W-1:0] ioAddr
);
  assert_setup_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    ioClk |-> ($stable(ioAddr) && $stable(ioDout)));
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ioClk) |-> ($stable(ioAddr) && $stable(ioDout)));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    ioClk |=> !ioClk);
  assert_no_idle_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !ioClk);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  assert_done_once_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (ioAddr != $past(ioAddr))) |->
      (ioAddr == $past(ioAddr) + ADDR_W'(1)));
endmodule

bind bitPortCtl bitPortChecker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done),
  .ioClk(ioClk), .ioDout(ioDout), .ioAddr(ioAddr)
);

// File: tb/bitPortCtl_tb.sv
module bitPortCtl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [11:0] cmdBase = '0;
  logic [3:0]  cmdCount = '0;
  logic [15:0] cmdData = '0;
  logic        busy, done, testFlag, ioDout, ioClk, ioDin;
  logic [15:0] rdData;
  logic [11:0] ioAddr;

  logic [4095:0] periph = '0;
  logic [4095:0] model  = '0;
  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  bitPortCtl dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBase(cmdBase), .cmdCount(cmdCount), .cmdData(cmdData),
    .busy(busy), .done(done), .rdData(rdData), .testFlag(testFlag),
    .ioAddr(ioAddr), .ioDout(ioDout), .ioClk(ioClk), .ioDin(ioDin)
  );

  always @(posedge ioClk) periph[ioAddr] <= ioDout;
  assign ioDin = periph[ioAddr];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bitsOf(input logic [2:0] op, input logic [3:0] cnt);
    if (op == 3'd3 || op == 3'd4) return (cnt == 0) ? 16 : int'(cnt);
    return 1;
  endfunction

  function automatic int cyclesOf(input logic [2:0] op, input logic [3:0] cnt);
    if (op == 3'd2 || op == 3'd4) return 2 * bitsOf(op, cnt);
    return 3 * bitsOf(op, cnt);
  endfunction

  function automatic logic [15:0] loadExp(input logic [11:0] base, input logic [3:0] cnt);
    logic [15:0] r = '0;
    for (int i = 0; i < bitsOf(3'd4, cnt); i++) r[i] = model[base + 12'(i)];
    return r;
  endfunction

  function automatic void applyModel(input logic [2:0] op, input logic [11:0] base,
                                     input logic [3:0] cnt, input logic [15:0] data);
    if (op == 3'd0) model[base] = 1'b1;
    else if (op == 3'd1) model[base] = 1'b0;
    else if (op == 3'd3)
      for (int i = 0; i < bitsOf(op, cnt); i++) model[base + 12'(i)] = data[i];
  endfunction

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // Issue a command and check busy length, done, and results.
  task automatic runCmd(input string req, input logic [2:0] op, input logic [11:0] base,
                        input logic [3:0] cnt, input logic [15:0] data, input bit intrude);
    int cyc = 0;
    logic [15:0] expRd;
    logic expFlag;
    expRd = loadExp(base, cnt);
    expFlag = model[base];
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdBase = base; cmdCount = cnt; cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0;
    while (busy && cyc < 100) begin
      cyc++;
      if (intrude && cyc == 2) begin
        cmdValid = 1'b1; cmdOp = 3'd0; cmdBase = base ^ 12'h800;
      end else cmdValid = 1'b0;
      @(negedge clk);
    end
    cmdValid = 1'b0;
    if (cyc >= 100) begin
      $display("FAIL watchdog %s", req);
      mismatched++;
      finishRun();
    end
    check({req, " busy cycles"}, 32'(cyc), 32'(cyclesOf(op, cnt)));
    check({req, "/R9 done"}, 32'(done), 32'd1);
    applyModel(op, base, cnt, data);
    if (op == 3'd2) check({req, " testFlag"}, 32'(testFlag), 32'(expFlag));
    if (op == 3'd4) check({req, " rdData"}, 32'(rdData), 32'(expRd));
    @(negedge clk);
    check({req, "/R9 done drop"}, 32'(done), 32'd0);
    check({req, " periph"}, 32'(periph == model), 32'd1);
  endtask

  initial begin
    #2_000_000;
    $display("FAIL watchdog expired");
    mismatched++;
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R10 busy", 32'(busy), 0);
    check("R10 done", 32'(done), 0);
    check("R10 ioClk", 32'(ioClk), 0);
    check("R10 ioAddr", 32'(ioAddr), 0);
    rstN = 1'b1;

    runCmd("R1 set one", 3'd0, 12'h123, 4'd0, 16'h0, 0);
    runCmd("R3 test one", 3'd2, 12'h123, 4'd0, 16'h0, 0);
    runCmd("R2 set zero", 3'd1, 12'h123, 4'd0, 16'hFFFF, 0);
    runCmd("R3 test zero", 3'd2, 12'h123, 4'd0, 16'h0, 0);
    runCmd("R4 store 3", 3'd3, 12'h200, 4'd3, 16'hFFFD, 0);
    runCmd("R4 store 16", 3'd3, 12'h300, 4'd0, 16'hA5C3, 0);
    runCmd("R5 load 16", 3'd4, 12'h300, 4'd0, 16'h0, 0);
    runCmd("R5 load 5", 3'd4, 12'h300, 4'd5, 16'h0, 0);
    runCmd("R7 wrap store", 3'd3, 12'hFFA, 4'd0, 16'h6E29, 0);
    runCmd("R7 wrap load", 3'd4, 12'hFFA, 4'd9, 16'h0, 0);
    runCmd("R8 intrude", 3'd3, 12'h400, 4'd7, 16'h0055, 1);

    // R8: unknown op codes do nothing
    for (int k = 5; k < 8; k++) begin
      @(negedge clk);
      cmdValid = 1'b1; cmdOp = 3'(k); cmdBase = 12'h010; cmdData = 16'hFFFF;
      @(negedge clk);
      cmdValid = 1'b0;
      check("R8 bad op busy", 32'(busy), 0);
      check("R8 bad op periph", 32'(periph == model), 1);
    end

    for (int n = 0; n < 60; n++) begin
      logic [2:0] op = 3'($urandom_range(0, 4));
      logic [11:0] base = 12'($urandom);
      logic [3:0] cnt = 4'($urandom);
      logic [15:0] data = 16'($urandom);
      case (op)
        3'd0: runCmd("R1 rand", op, base, cnt, data, 0);
        3'd1: runCmd("R2 rand", op, base, cnt, data, 0);
        3'd2: runCmd("R3 rand", op, base, cnt, data, 0);
        3'd3: runCmd("R4 rand", op, base, cnt, data, 0);
        default: runCmd("R5 rand", op, base, cnt, data, 0);
      endcase
    end
    finishRun();
  end
endmodule